// File: doc/BRIEF.md
# Split I/D request dispatcher

This block stands in front of a pair of level-one tag arrays, one holding instruction lines and one holding data lines. Each cycle it looks at the heads of four request queues: prefetch, response, forwarded request and processor. It picks one of them by fixed priority and turns that head into a single event aimed at one cache line. A downstream coherence controller consumes the event and acts on it; the coherence actions themselves are outside this block.

For processor and prefetch requests the dispatcher drives a lookup line to both tag arrays. It reads back the present, free-way and victim answers and decides what to dispatch:
- the request's own event on the requested line, or
- a replacement event on a line that has to leave a cache first.

That line is either the requested line sitting in the wrong cache, or the target cache's victim. Response and forwarded requests are decoded straight into events on their own line.

A processor request that the controller cannot take yet is parked. The processor queue then drops out of arbitration until a wake-up names the parked line.

States of the park controller:
- SERVE: the processor queue competes for the dispatch slot.
- PARKED: the processor queue is masked.

Transitions:
- SERVE to PARKED when a processor event is presented together with a stall.
- PARKED to SERVE when a wake-up carries the parked line.
- PARKED stays PARKED on any other wake-up or on none.

Top module: `split_dispatch`

## Requirements
- R1: Queue priority is fixed: prefetch is served first, then response, then forwarded request, then processor. Only the winner's pop output may rise.
- R2: At most one event is presented per cycle (`evt_valid`). The winning queue's pop is raised only in a cycle where `evt_ready` is high. With `evt_ready` low the event stays presented and no pop is raised.
- R3: Request type codes are 0 load, 1 ifetch, 2 store, 3 atomic. A processor request maps load to event 1 (Load), ifetch to event 2 (Ifetch), and both store and atomic to event 3 (Store). An ifetch is looked up in the I-cache and every other type in the D-cache. `evt_icache` is 1 when the event targets the I-cache.
- R4: A processor request whose line is present in its own cache dispatches its own event on the requested line, in that cache.
- R5: A processor request whose line is absent from its own cache but present in the opposite cache dispatches event 4 (Replace) on the requested line, aimed at the opposite cache.
- R6: A processor request whose line is in neither cache dispatches its own event on the requested line if the target cache reports a free way. Otherwise it dispatches event 4 (Replace) on the target cache's victim line, aimed at the target cache.
- R7: A prefetch maps load to event 5, ifetch to event 6, and store or atomic to event 7. If the line is present in either cache, the prefetch event is dispatched on the requested line, aimed at the cache that holds it, so the controller can drop it. If the line is absent, the rule of R6 applies, with the prefetch event in place of the processor event.
- R8: Response kinds 0 to 3 (data, exclusive data, ack, writeback ack) dispatch events 12 to 15. Forwarded kinds dispatch as follows: 0 (invalidate) to event 8, 1 and 2 (exclusive request and upgrade) both to event 9, 3 (shared request) to event 10, and 4 (instruction request) to event 11. These events carry the queue's own line. Kinds 5 to 7 are illegal.
- R9: A processor event presented with `evt_stall` high is not popped, and the processor queue is parked. While parked, the processor queue is never served, but the other queues still are.
- R10: A wake-up whose line equals the parked line returns the processor queue to arbitration in the next cycle. A wake-up on any other line has no effect.
- R11: A line flagged as in a transient state (`lk_busy`) is never reported present in both caches at once.
- R12: While reset is asserted no event is presented and no queue is popped. After reset the processor queue is not parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch queue head valid |
| pf_type | input | 2 | Prefetch request type (R3 codes) |
| pf_line | input | ADDR_W | Prefetch line address |
| pf_pop | output | 1 | Pop prefetch queue |
| rsp_valid | input | 1 | Response queue head valid |
| rsp_kind | input | 2 | Response kind (R8 codes) |
| rsp_line | input | ADDR_W | Response line address |
| rsp_pop | output | 1 | Pop response queue |
| fwd_valid | input | 1 | Forwarded request queue head valid |
| fwd_kind | input | 3 | Forwarded request kind (R8 codes) |
| fwd_line | input | ADDR_W | Forwarded request line address |
| fwd_pop | output | 1 | Pop forwarded request queue |
| cpu_valid | input | 1 | Processor queue head valid |
| cpu_type | input | 2 | Processor request type (R3 codes) |
| cpu_line | input | ADDR_W | Processor line address |
| cpu_pop | output | 1 | Pop processor queue |
| lk_line | output | ADDR_W | Line looked up in both tag arrays |
| ic_hit | input | 1 | Looked-up line present in I-cache |
| dc_hit | input | 1 | Looked-up line present in D-cache |
| ic_free | input | 1 | I-cache set has a free way |
| dc_free | input | 1 | D-cache set has a free way |
| ic_victim | input | ADDR_W | I-cache victim line for the looked-up set |
| dc_victim | input | ADDR_W | D-cache victim line for the looked-up set |
| lk_busy | input | 1 | Looked-up line is in a transient state |
| evt_valid | output | 1 | Event presented |
| evt_code | output | 4 | Event code (R3 to R8) |
| evt_line | output | ADDR_W | Line the event acts on |
| evt_icache | output | 1 | Event targets the I-cache |
| evt_ready | input | 1 | Controller accepts the event |
| evt_stall | input | 1 | Controller stalls the presented processor event |
| wake_valid | input | 1 | Wake-up for a line |
| wake_line | input | ADDR_W | Line being woken |

## Verification
The bench builds the block with `ADDR_W = 8`. Each queue, both victims and the wake-up line can then carry a distinct, readable line value. A wrong line routed to `evt_line`, whether another queue's line, the wrong victim or the requested line instead of the victim, shows up as a visibly different value. The same width is wide enough for a non-matching wake-up that differs from the parked line in one bit, so address comparison in the park controller is exercised.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    typedef enum logic [1:0] {
        RQ_LOAD   = 2'd0,
        RQ_IFETCH = 2'd1,
        RQ_STORE  = 2'd2,
        RQ_ATOMIC = 2'd3
    } rq_type_e;

    typedef enum logic [3:0] {
        EV_NONE      = 4'd0,
        EV_LOAD      = 4'd1,
        EV_IFETCH    = 4'd2,
        EV_STORE     = 4'd3,
        EV_REPL      = 4'd4,
        EV_PF_LOAD   = 4'd5,
        EV_PF_IFETCH = 4'd6,
        EV_PF_STORE  = 4'd7,
        EV_INV       = 4'd8,
        EV_FWD_EXCL  = 4'd9,
        EV_FWD_SHRD  = 4'd10,
        EV_FWD_INSTR = 4'd11,
        EV_DATA      = 4'd12,
        EV_DATA_EXCL = 4'd13,
        EV_ACK       = 4'd14,
        EV_WB_ACK    = 4'd15
    } evt_e;

    typedef enum logic {
        PK_SERVE  = 1'b0,
        PK_PARKED = 1'b1
    } park_e;

    // queue index equals its priority rank
    localparam int NUM_Q = 4;
    localparam int Q_CPU = 0;
    localparam int Q_FWD = 1;
    localparam int Q_RSP = 2;
    localparam int Q_PF  = 3;

endpackage

// File: rtl/dsp_arbiter.sv
module dsp_arbiter #(
    parameter int NUM_Q = 4
) (
    input  logic [NUM_Q-1:0] req,
    output logic [NUM_Q-1:0] grant,
    output logic             any
);
    // above[k]: some request at index k or higher
    logic [NUM_Q:0] above;

    assign above[NUM_Q] = 1'b0;

    generate
        for (genvar k = 0; k < NUM_Q; k++) begin : g_rank
            assign above[k] = above[k+1] | req[k];
            assign grant[k] = req[k] & ~above[k+1];
        end
    endgenerate

    assign any = above[0];

endmodule

// File: rtl/dsp_classify.sv
module dsp_classify
    import dsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              is_pf,
    input  rq_type_e          rtype,
    input  logic [ADDR_W-1:0] line,
    input  logic              ic_hit,
    input  logic              dc_hit,
    input  logic              ic_free,
    input  logic              dc_free,
    input  logic [ADDR_W-1:0] ic_victim,
    input  logic [ADDR_W-1:0] dc_victim,
    output evt_e              evt,
    output logic [ADDR_W-1:0] evt_line,
    output logic              evt_icache
);
    logic              want_i;
    logic              own_hit;
    logic              oth_hit;
    logic              own_free;
    logic [ADDR_W-1:0] own_vic;
    evt_e              own_evt;

    always_comb begin
        want_i   = (rtype == RQ_IFETCH);
        own_hit  = want_i ? ic_hit    : dc_hit;
        oth_hit  = want_i ? dc_hit    : ic_hit;
        own_free = want_i ? ic_free   : dc_free;
        own_vic  = want_i ? ic_victim : dc_victim;

        own_evt = EV_NONE;
        unique case (rtype)
            RQ_LOAD:             own_evt = is_pf ? EV_PF_LOAD   : EV_LOAD;
            RQ_IFETCH:           own_evt = is_pf ? EV_PF_IFETCH : EV_IFETCH;
            RQ_STORE, RQ_ATOMIC: own_evt = is_pf ? EV_PF_STORE  : EV_STORE;
        endcase

        evt        = own_evt;
        evt_line   = line;
        evt_icache = want_i;

        if (own_hit) begin
            // hit in the matching cache: request event as is
        end else if (oth_hit) begin
            // line lives in the opposite cache
            evt_icache = ~want_i;
            if (!is_pf) begin
                evt = EV_REPL;
            end
        end else if (!own_free) begin
            evt      = EV_REPL;
            evt_line = own_vic;
        end
    end

endmodule

// File: rtl/dsp_park_fsm.sv
module dsp_park_fsm
    import dsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_take,
    input  logic [ADDR_W-1:0] stall_line,
    input  logic              wake_valid,
    input  logic [ADDR_W-1:0] wake_line,
    output logic              parked,
    output logic [ADDR_W-1:0] park_line
);
    park_e             st_q, st_nx;
    logic [ADDR_W-1:0] line_q, line_nx;
    logic              wake_hit;

    assign wake_hit = wake_valid && (wake_line == line_q);

    always_comb begin
        st_nx   = st_q;
        line_nx = line_q;
        unique case (st_q)
            PK_SERVE: begin
                if (stall_take) begin
                    st_nx   = PK_PARKED;
                    line_nx = stall_line;
                end
            end
            PK_PARKED: begin
                if (wake_hit) begin
                    st_nx = PK_SERVE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PK_SERVE;
            line_q <= '0;
        end else begin
            st_q   <= st_nx;
            line_q <= line_nx;
        end
    end

    always_comb begin
        parked    = (st_q == PK_PARKED);
        park_line = line_q;
    end

    // R10: a matching wake-up leaves the parked state
    assert_wake_resumes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && wake_valid && wake_line == park_line) |=> !parked);

    // R10: any other wake-up keeps the queue parked on the same line
    assert_wrong_wake_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && !(wake_valid && wake_line == park_line)) |=> (parked && $stable(park_line)));

endmodule

// File: rtl/split_dispatch.sv
module split_dispatch
    import dsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_valid,
    input  logic [1:0]        pf_type,
    input  logic [ADDR_W-1:0] pf_line,
    output logic              pf_pop,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_kind,
    input  logic [ADDR_W-1:0] rsp_line,
    output logic              rsp_pop,
    input  logic              fwd_valid,
    input  logic [2:0]        fwd_kind,
    input  logic [ADDR_W-1:0] fwd_line,
    output logic              fwd_pop,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_type,
    input  logic [ADDR_W-1:0] cpu_line,
    output logic              cpu_pop,
    output logic [ADDR_W-1:0] lk_line,
    input  logic              ic_hit,
    input  logic              dc_hit,
    input  logic              ic_free,
    input  logic              dc_free,
    input  logic [ADDR_W-1:0] ic_victim,
    input  logic [ADDR_W-1:0] dc_victim,
    input  logic              lk_busy,
    output logic              evt_valid,
    output logic [3:0]        evt_code,
    output logic [ADDR_W-1:0] evt_line,
    output logic              evt_icache,
    input  logic              evt_ready,
    input  logic              evt_stall,
    input  logic              wake_valid,
    input  logic [ADDR_W-1:0] wake_line
);
    logic [NUM_Q-1:0]  req;
    logic [NUM_Q-1:0]  grant;
    logic              any;
    logic              parked;
    logic [ADDR_W-1:0] park_line;
    logic              take;
    logic              stall_take;

    evt_e              cls_evt;
    logic [ADDR_W-1:0] cls_line;
    logic              cls_icache;
    rq_type_e          lk_type;
    evt_e              rsp_evt;
    evt_e              fwd_evt;

    assign req[Q_PF]  = rst_n & pf_valid;
    assign req[Q_RSP] = rst_n & rsp_valid;
    assign req[Q_FWD] = rst_n & fwd_valid;
    assign req[Q_CPU] = rst_n & cpu_valid & ~parked;

    dsp_arbiter #(.NUM_Q(NUM_Q)) u_arb (
        .req   (req),
        .grant (grant),
        .any   (any)
    );

    assign lk_line = grant[Q_PF] ? pf_line : cpu_line;
    assign lk_type = rq_type_e'(grant[Q_PF] ? pf_type : cpu_type);

    dsp_classify #(.ADDR_W(ADDR_W)) u_cls (
        .is_pf      (grant[Q_PF]),
        .rtype      (lk_type),
        .line       (lk_line),
        .ic_hit     (ic_hit),
        .dc_hit     (dc_hit),
        .ic_free    (ic_free),
        .dc_free    (dc_free),
        .ic_victim  (ic_victim),
        .dc_victim  (dc_victim),
        .evt        (cls_evt),
        .evt_line   (cls_line),
        .evt_icache (cls_icache)
    );

    always_comb begin
        rsp_evt = EV_DATA;
        unique case (rsp_kind)
            2'd0: rsp_evt = EV_DATA;
            2'd1: rsp_evt = EV_DATA_EXCL;
            2'd2: rsp_evt = EV_ACK;
            2'd3: rsp_evt = EV_WB_ACK;
        endcase
        fwd_evt = EV_INV;
        case (fwd_kind)
            3'd0:       fwd_evt = EV_INV;
            3'd1, 3'd2: fwd_evt = EV_FWD_EXCL;
            3'd3:       fwd_evt = EV_FWD_SHRD;
            3'd4:       fwd_evt = EV_FWD_INSTR;
            default:    fwd_evt = EV_INV;
        endcase
    end

    // output process: event mux by granted queue
    always_comb begin
        evt_valid  = any;
        evt_code   = EV_NONE;
        evt_line   = '0;
        evt_icache = 1'b0;
        if (grant[Q_PF] || grant[Q_CPU]) begin
            evt_code   = cls_evt;
            evt_line   = cls_line;
            evt_icache = cls_icache;
        end else if (grant[Q_RSP]) begin
            evt_code = rsp_evt;
            evt_line = rsp_line;
        end else if (grant[Q_FWD]) begin
            evt_code = fwd_evt;
            evt_line = fwd_line;
        end
    end

    assign take       = evt_valid & evt_ready;
    assign stall_take = evt_valid & evt_stall & grant[Q_CPU];

    assign pf_pop  = take & grant[Q_PF];
    assign rsp_pop = take & grant[Q_RSP];
    assign fwd_pop = take & grant[Q_FWD];
    assign cpu_pop = take & grant[Q_CPU] & ~evt_stall;

    dsp_park_fsm #(.ADDR_W(ADDR_W)) u_park (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_take (stall_take),
        .stall_line (cpu_line),
        .wake_valid (wake_valid),
        .wake_line  (wake_line),
        .parked     (parked),
        .park_line  (park_line)
    );

    assert_prefetch_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (evt_valid && !rsp_pop && !fwd_pop && !cpu_pop));

    assert_response_over_lower_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !pf_valid) |-> (!fwd_pop && !cpu_pop));

    assert_single_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pf_pop, rsp_pop, fwd_pop, cpu_pop}));

    assert_pop_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_pop || rsp_pop || fwd_pop || cpu_pop) |-> (evt_valid && evt_ready));

    assert_own_hit_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !parked && !pf_valid && !rsp_valid && !fwd_valid
         && cpu_type == 2'd1 && ic_hit) |-> (evt_line == cpu_line && evt_icache));

    assert_wrong_cache_evicts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !parked && !pf_valid && !rsp_valid && !fwd_valid
         && cpu_type == 2'd0 && !dc_hit && ic_hit)
        |-> (evt_code == 4'd4 && evt_line == cpu_line && evt_icache));

    assert_full_set_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !parked && !pf_valid && !rsp_valid && !fwd_valid
         && cpu_type == 2'd2 && !dc_hit && !ic_hit && !dc_free)
        |-> (evt_code == 4'd4 && evt_line == dc_victim && !evt_icache));

    assert_present_prefetch_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && (ic_hit || dc_hit)) |-> (evt_line == pf_line && evt_code != 4'd4));

    assert_fwd_kind_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_kind <= 3'd4));

    assert_parked_no_cpu_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> !cpu_pop);

    assert_stall_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !parked && !pf_valid && !rsp_valid && !fwd_valid && evt_stall)
        |=> parked);

    assert_no_dual_residence_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_busy |-> !(ic_hit && dc_hit));

endmodule

// File: tb/split_dispatch_tb.sv
`timescale 1ns/1ps
module split_dispatch_tb;

    localparam int AW = 8;
    localparam logic [AW-1:0] PF_A = 8'h30, RSP_A = 8'h20, FWD_A = 8'h40, CPU_A = 8'h10;
    localparam logic [AW-1:0] IV_A = 8'hA1, DV_A = 8'hD1;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n;
    logic pf_valid, rsp_valid, fwd_valid, cpu_valid;
    logic [1:0] pf_type, rsp_kind, cpu_type;
    logic [2:0] fwd_kind;
    logic [AW-1:0] pf_line, rsp_line, fwd_line, cpu_line;
    logic pf_pop, rsp_pop, fwd_pop, cpu_pop;
    logic [AW-1:0] lk_line;
    logic ic_hit, dc_hit, ic_free, dc_free, lk_busy;
    logic [AW-1:0] ic_victim, dc_victim;
    logic evt_valid, evt_icache, evt_ready, evt_stall, wake_valid;
    logic [3:0] evt_code;
    logic [AW-1:0] evt_line, wake_line;

    split_dispatch #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pf_valid(pf_valid), .pf_type(pf_type), .pf_line(pf_line), .pf_pop(pf_pop),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_line(rsp_line), .rsp_pop(rsp_pop),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_line(fwd_line), .fwd_pop(fwd_pop),
        .cpu_valid(cpu_valid), .cpu_type(cpu_type), .cpu_line(cpu_line), .cpu_pop(cpu_pop),
        .lk_line(lk_line), .ic_hit(ic_hit), .dc_hit(dc_hit), .ic_free(ic_free),
        .dc_free(dc_free), .ic_victim(ic_victim), .dc_victim(dc_victim), .lk_busy(lk_busy),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_line(evt_line),
        .evt_icache(evt_icache), .evt_ready(evt_ready), .evt_stall(evt_stall),
        .wake_valid(wake_valid), .wake_line(wake_line)
    );

    // v and ep: {pf, rsp, fwd, cpu}; tg: {ic_hit, dc_hit, ic_free, dc_free}
    typedef struct packed {
        logic [3:0] v;
        logic [1:0] pt;
        logic [1:0] ct;
        logic [1:0] rk;
        logic [2:0] fk;
        logic [3:0] tg;
        logic [3:0] ee;
        logic [7:0] ea;
        logic       ei;
        logic [3:0] ep;
        logic [3:0] rn;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0100, 4'd1,  8'h10, 1'b0, 4'b0001, 4'd3}, // R3 load, D hit
        '{4'b0001, 2'd0, 2'd1, 2'd0, 3'd0, 4'b1000, 4'd2,  8'h10, 1'b1, 4'b0001, 4'd4}, // R4 ifetch, I hit
        '{4'b0001, 2'd0, 2'd2, 2'd0, 3'd0, 4'b0100, 4'd3,  8'h10, 1'b0, 4'b0001, 4'd3}, // R3 store
        '{4'b0001, 2'd0, 2'd3, 2'd0, 3'd0, 4'b0100, 4'd3,  8'h10, 1'b0, 4'b0001, 4'd3}, // R3 atomic
        '{4'b0001, 2'd0, 2'd1, 2'd0, 3'd0, 4'b0100, 4'd4,  8'h10, 1'b0, 4'b0001, 4'd5}, // R5 ifetch in D
        '{4'b0001, 2'd0, 2'd0, 2'd0, 3'd0, 4'b1000, 4'd4,  8'h10, 1'b1, 4'b0001, 4'd5}, // R5 load in I
        '{4'b0001, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0001, 4'd1,  8'h10, 1'b0, 4'b0001, 4'd6}, // R6 miss, free
        '{4'b0001, 2'd0, 2'd1, 2'd0, 3'd0, 4'b0001, 4'd4,  8'hA1, 1'b1, 4'b0001, 4'd6}, // R6 I full
        '{4'b0001, 2'd0, 2'd2, 2'd0, 3'd0, 4'b0010, 4'd4,  8'hD1, 1'b0, 4'b0001, 4'd6}, // R6 D full
        '{4'b1000, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0100, 4'd5,  8'h30, 1'b0, 4'b1000, 4'd7}, // R7 pf load present
        '{4'b1000, 2'd1, 2'd0, 2'd0, 3'd0, 4'b0100, 4'd6,  8'h30, 1'b0, 4'b1000, 4'd7}, // R7 pf ifetch in D
        '{4'b1000, 2'd2, 2'd0, 2'd0, 3'd0, 4'b1000, 4'd7,  8'h30, 1'b1, 4'b1000, 4'd7}, // R7 pf store in I
        '{4'b1000, 2'd1, 2'd0, 2'd0, 3'd0, 4'b0010, 4'd6,  8'h30, 1'b1, 4'b1000, 4'd7}, // R7 pf miss, free
        '{4'b1000, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0010, 4'd4,  8'hD1, 1'b0, 4'b1000, 4'd7}, // R7 pf miss, full
        '{4'b0100, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0000, 4'd12, 8'h20, 1'b0, 4'b0100, 4'd8}, // R8 data
        '{4'b0100, 2'd0, 2'd0, 2'd1, 3'd0, 4'b0000, 4'd13, 8'h20, 1'b0, 4'b0100, 4'd8}, // R8 excl data
        '{4'b0100, 2'd0, 2'd0, 2'd2, 3'd0, 4'b0000, 4'd14, 8'h20, 1'b0, 4'b0100, 4'd8}, // R8 ack
        '{4'b0100, 2'd0, 2'd0, 2'd3, 3'd0, 4'b0000, 4'd15, 8'h20, 1'b0, 4'b0100, 4'd8}, // R8 wb ack
        '{4'b0010, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0000, 4'd8,  8'h40, 1'b0, 4'b0010, 4'd8}, // R8 inv
        '{4'b0010, 2'd0, 2'd0, 2'd0, 3'd1, 4'b0000, 4'd9,  8'h40, 1'b0, 4'b0010, 4'd8}, // R8 excl req
        '{4'b0010, 2'd0, 2'd0, 2'd0, 3'd2, 4'b0000, 4'd9,  8'h40, 1'b0, 4'b0010, 4'd8}, // R8 upgrade
        '{4'b0010, 2'd0, 2'd0, 2'd0, 3'd3, 4'b0000, 4'd10, 8'h40, 1'b0, 4'b0010, 4'd8}, // R8 shared req
        '{4'b0010, 2'd0, 2'd0, 2'd0, 3'd4, 4'b0000, 4'd11, 8'h40, 1'b0, 4'b0010, 4'd8}, // R8 instr req
        '{4'b1111, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0100, 4'd5,  8'h30, 1'b0, 4'b1000, 4'd1}, // R1 all valid
        '{4'b0111, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0100, 4'd12, 8'h20, 1'b0, 4'b0100, 4'd1}, // R1 no prefetch
        '{4'b0011, 2'd0, 2'd0, 2'd0, 3'd0, 4'b0100, 4'd8,  8'h40, 1'b0, 4'b0010, 4'd1}  // R1 fwd over cpu
    };

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pops();
        return {pf_pop, rsp_pop, fwd_pop, cpu_pop};
    endfunction

    task automatic idle_inputs();
        {pf_valid, rsp_valid, fwd_valid, cpu_valid} = 4'b0;
        pf_type = 2'd0; cpu_type = 2'd0; rsp_kind = 2'd0; fwd_kind = 3'd0;
        {ic_hit, dc_hit, ic_free, dc_free} = 4'b0;
        lk_busy = 1'b0; evt_ready = 1'b1; evt_stall = 1'b0;
        wake_valid = 1'b0; wake_line = '0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pf_line = PF_A; rsp_line = RSP_A; fwd_line = FWD_A; cpu_line = CPU_A;
        ic_victim = IV_A; dc_victim = DV_A;
        idle_inputs();
        rst_n = 1'b0;

        // R12: reset holds everything quiet even with all queues valid
        @(negedge clk);
        {pf_valid, rsp_valid, fwd_valid, cpu_valid} = 4'b1111;
        dc_hit = 1'b1;
        #2;
        chk("R12", "evt_valid in reset", {31'b0, evt_valid}, 32'd0);
        chk("R12", "pops in reset", {28'b0, pops()}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle_inputs();
        cpu_valid = 1'b1; dc_hit = 1'b1;
        #2;
        chk("R12", "cpu served after reset", {28'b0, pops()}, 32'b0001);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            {pf_valid, rsp_valid, fwd_valid, cpu_valid} = VECS[i].v;
            pf_type = VECS[i].pt; cpu_type = VECS[i].ct;
            rsp_kind = VECS[i].rk; fwd_kind = VECS[i].fk;
            {ic_hit, dc_hit, ic_free, dc_free} = VECS[i].tg;
            #2;
            chk($sformatf("R%0d", VECS[i].rn), $sformatf("vec %0d code", i), {28'b0, evt_code}, {28'b0, VECS[i].ee});
            chk($sformatf("R%0d", VECS[i].rn), $sformatf("vec %0d line", i), {24'b0, evt_line}, {24'b0, VECS[i].ea});
            chk($sformatf("R%0d", VECS[i].rn), $sformatf("vec %0d icache", i), {31'b0, evt_icache}, {31'b0, VECS[i].ei});
            chk($sformatf("R%0d", VECS[i].rn), $sformatf("vec %0d pops", i), {28'b0, pops()}, {28'b0, VECS[i].ep});
        end

        // R2: controller not ready
        @(negedge clk);
        idle_inputs();
        cpu_valid = 1'b1; dc_hit = 1'b1; evt_ready = 1'b0;
        #2;
        chk("R2", "event held when not ready", {31'b0, evt_valid}, 32'd1);
        chk("R2", "no pop when not ready", {28'b0, pops()}, 32'd0);

        // R11: transient line present in one cache only
        @(negedge clk);
        idle_inputs();
        cpu_valid = 1'b1; ic_hit = 1'b1; cpu_type = 2'd1; lk_busy = 1'b1;
        #2;
        chk("R11", "busy line single residence", {28'b0, evt_code}, 32'd2);

        // R9: stall parks the processor queue
        @(negedge clk);
        idle_inputs();
        cpu_valid = 1'b1; dc_hit = 1'b1; evt_stall = 1'b1;
        #2;
        chk("R9", "stalled cpu not popped", {31'b0, cpu_pop}, 32'd0);
        @(negedge clk);
        evt_stall = 1'b0;
        #2;
        chk("R9", "parked cpu not presented", {31'b0, evt_valid}, 32'd0);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_kind = 2'd2;
        #2;
        chk("R9", "response served while parked", {28'b0, evt_code}, 32'd14);
        chk("R9", "response pop while parked", {28'b0, pops()}, 32'b0100);

        // R10: wrong wake-up is ignored
        @(negedge clk);
        rsp_valid = 1'b0;
        wake_valid = 1'b1; wake_line = 8'h11;
        @(negedge clk);
        wake_valid = 1'b0;
        #2;
        chk("R10", "wrong wake keeps parked", {31'b0, evt_valid}, 32'd0);

        // R10: matching wake-up resumes
        @(negedge clk);
        wake_valid = 1'b1; wake_line = CPU_A;
        @(negedge clk);
        wake_valid = 1'b0;
        #2;
        chk("R10", "resumed evt_valid", {31'b0, evt_valid}, 32'd1);
        chk("R10", "resumed code", {28'b0, evt_code}, 32'd1);
        chk("R10", "resumed pop", {28'b0, pops()}, 32'b0001);

        @(negedge clk);
        idle_inputs();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule